// File: doc/BRIEF.md
# Stack Pointer Unit with Extended Addressing

This block holds the stack pointer of an 8-bit microcontroller core. The pointer is made of a low byte and a small high byte. Both are visible as special-function registers, and so is a configuration register. A mode bit in that configuration register picks the pointer format. In classic mode only the low byte counts and it wraps within 256 locations. In extended mode the high byte supplies the upper pointer bits, giving an 11-bit stack address.

The instruction sequencer presents one stack operation per cycle. A single-byte push pre-increments the pointer and writes at the new value. A single-byte pop reads at the current value and then decrements. A call pushes two bytes and a return pops two, each in one cycle. For these two-byte operations the unit gives one address per byte, so both RAM accesses can be issued together. The RAM, the instruction decode and the interrupt logic sit outside this unit.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the low byte reads 07h, the high byte reads 00h and the configuration register reads 00h, which selects classic mode. The first push after reset therefore addresses 008h.
- R2: Operation code 1 (push) presents address pointer+1 on both address outputs and leaves the pointer at pointer+1.
- R3: Operation code 2 (pop) presents the current pointer on both address outputs and leaves the pointer at pointer-1.
- R4: Operation code 3 (call) presents pointer+1 on the first address output and pointer+2 on the second, and leaves the pointer at pointer+2. Operation code 4 (return) presents the pointer on the first output and pointer-1 on the second, and leaves the pointer at pointer-2. Code 0 (idle) presents the pointer on both outputs and changes nothing.
- R5: In classic mode the low byte wraps in both directions: a push from FFh goes to 00h, and a pop from 00h goes to FFh. The high byte keeps its value through all stack operations.
- R6: In extended mode the pointer is {high[2:0], low}. A push from 0FFh gives 100h. The pointer wraps from 7FFh to 000h going up, and from 000h to 7FFh going down.
- R7: The high byte has three storage bits. SFR bits 7:3 of the high byte always read 0, and any data written to those bits is discarded.
- R8: When an SFR write to the low byte or the high byte falls in the same cycle as a stack operation, the stack operation's pointer update is dropped. The written byte takes the write data, and the other byte keeps its value.
- R9: SFR select 0 is the low byte, 1 is the high byte, 2 is the configuration register and 3 reads 00h. The read is combinational. Configuration bit 7 is the extended-mode enable, and the other configuration bits read 0.
- R10: In classic mode the high byte does not affect addressing, and address bits 10:8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stk_op_i | input | 3 | Stack operation: 0 idle, 1 push, 2 pop, 3 call, 4 return |
| sfr_sel_i | input | 2 | SFR select for read and write |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for the selected register |
| stk_addr_o | output | 11 | Stack RAM address for the first byte of the operation |
| stk_addr2_o | output | 11 | Stack RAM address for the second byte of a call or return |

## Verification
The assertions assume the operation code is always one of the five defined values. They also assume the sequencer holds the pointer within whatever depth it needs, and they treat wraparound as legal behaviour. The step checks apply only when no SFR write hits a pointer byte in that cycle, because R8 overrides the arithmetic. The stimulus drives only defined operation codes. It changes the mode only through an SFR write on a cycle with no stack operation, so mode and pointer never change together. It does, however, deliberately collide pointer writes with push and pop.

// File: rtl/stkp_pkg.sv
`timescale 1ns/1ps
package stkp_pkg;
   typedef enum logic [2:0] {
      STK_IDLE = 3'd0,
      STK_PUSH = 3'd1,
      STK_POP  = 3'd2,
      STK_CALL = 3'd3,
      STK_RET  = 3'd4
   } stk_op_e;

   localparam logic [1:0] SEL_LO  = 2'd0;
   localparam logic [1:0] SEL_HI  = 2'd1;
   localparam logic [1:0] SEL_CFG = 2'd2;
endpackage

// File: rtl/stkp_cfg.sv
`timescale 1ns/1ps
module stkp_cfg #(
   parameter int BYTE_W      = 8,
   parameter int EXT_BIT     = 7,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic              ext_o
);
   generate
      if (EXT_SUPPORT) begin : g_ext
         logic ext_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   ext_q <= 1'b0;
            else if (wr_i) ext_q <= wdata_i[EXT_BIT];
         end
         assign ext_o = ext_q;
      end else begin : g_classic_only
         logic unused_w;
         assign unused_w = wr_i ^ (^wdata_i) ^ clk_i ^ rst_ni;
         assign ext_o    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/stkp_step.sv
`timescale 1ns/1ps
module stkp_step
   import stkp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PTR_W  = 11,
   localparam int HI_W  = PTR_W - BYTE_W
) (
   input  stk_op_e           op_i,
   input  logic              ext_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [HI_W-1:0]   hi_i,
   output logic [BYTE_W-1:0] nxt_lo_o,
   output logic [HI_W-1:0]   nxt_hi_o,
   output logic [PTR_W-1:0]  addr_a_o,
   output logic [PTR_W-1:0]  addr_b_o
);
   function automatic logic [PTR_W-1:0] fold(input logic [PTR_W-1:0] v, input logic e);
      return e ? v : {{HI_W{1'b0}}, v[BYTE_W-1:0]};
   endfunction

   logic [PTR_W-1:0] cur, p1, p2, m1, m2, nxt;

   assign cur = fold({hi_i, lo_i}, ext_i);
   assign p1  = fold(cur + PTR_W'(1), ext_i);
   assign p2  = fold(cur + PTR_W'(2), ext_i);
   assign m1  = fold(cur - PTR_W'(1), ext_i);
   assign m2  = fold(cur - PTR_W'(2), ext_i);

   always_comb begin
      addr_a_o = cur;
      addr_b_o = cur;
      nxt      = cur;
      unique case (op_i)
         STK_PUSH: begin addr_a_o = p1;  addr_b_o = p1; nxt = p1; end
         STK_CALL: begin addr_a_o = p1;  addr_b_o = p2; nxt = p2; end
         STK_POP:  begin addr_a_o = cur; addr_b_o = cur; nxt = m1; end
         STK_RET:  begin addr_a_o = cur; addr_b_o = m1; nxt = m2; end
         default:  ;
      endcase
   end

   assign nxt_lo_o = nxt[BYTE_W-1:0];
   assign nxt_hi_o = ext_i ? nxt[PTR_W-1:BYTE_W] : hi_i;
endmodule

// File: rtl/stkp_regs.sv
`timescale 1ns/1ps
module stkp_regs #(
   parameter int BYTE_W             = 8,
   parameter int PTR_W              = 11,
   parameter logic [7:0] RESET_LO   = 8'h07,
   localparam int HI_W              = PTR_W - BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              upd_i,
   input  logic [BYTE_W-1:0] nxt_lo_i,
   input  logic [HI_W-1:0]   nxt_hi_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [HI_W-1:0]   hi_o
);
   logic sfr_hit;
   assign sfr_hit = wr_lo_i | wr_hi_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_o <= BYTE_W'(RESET_LO);
         hi_o <= '0;
      end else if (sfr_hit) begin
         if (wr_lo_i) lo_o <= wdata_i;
         if (wr_hi_i) hi_o <= wdata_i[HI_W-1:0];
      end else if (upd_i) begin
         lo_o <= nxt_lo_i;
         hi_o <= nxt_hi_i;
      end
   end
endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
module stack_ptr_unit
   import stkp_pkg::*;
#(
   parameter int BYTE_W            = 8,
   parameter int PTR_W             = 11,
   parameter int EXT_BIT           = 7,
   parameter bit EXT_SUPPORT       = 1'b1,
   parameter logic [7:0] RESET_LO  = 8'h07
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        stk_op_i,
   input  logic [1:0]        sfr_sel_i,
   input  logic              sfr_wr_i,
   input  logic [BYTE_W-1:0] sfr_wdata_i,
   output logic [BYTE_W-1:0] sfr_rdata_o,
   output logic [PTR_W-1:0]  stk_addr_o,
   output logic [PTR_W-1:0]  stk_addr2_o
);
   localparam int HI_W = PTR_W - BYTE_W;

   generate
      if (PTR_W <= BYTE_W)      begin : g_chk_w  $error("PTR_W must exceed BYTE_W");   end
      if (HI_W > BYTE_W)        begin : g_chk_h  $error("high part exceeds one byte"); end
      if (EXT_BIT >= BYTE_W)    begin : g_chk_b  $error("EXT_BIT out of range");       end
   endgenerate

   stk_op_e             op;
   logic                ext;
   logic [BYTE_W-1:0]   ptr_lo, nxt_lo;
   logic [HI_W-1:0]     ptr_hi, nxt_hi;
   logic                wr_lo, wr_hi, wr_cfg;

   assign op     = stk_op_e'(stk_op_i);
   assign wr_lo  = sfr_wr_i && (sfr_sel_i == SEL_LO);
   assign wr_hi  = sfr_wr_i && (sfr_sel_i == SEL_HI);
   assign wr_cfg = sfr_wr_i && (sfr_sel_i == SEL_CFG);

   stkp_cfg #(.BYTE_W(BYTE_W), .EXT_BIT(EXT_BIT), .EXT_SUPPORT(EXT_SUPPORT)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_cfg),
      .wdata_i (sfr_wdata_i),
      .ext_o   (ext)
   );

   stkp_step #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_step (
      .op_i     (op),
      .ext_i    (ext),
      .lo_i     (ptr_lo),
      .hi_i     (ptr_hi),
      .nxt_lo_o (nxt_lo),
      .nxt_hi_o (nxt_hi),
      .addr_a_o (stk_addr_o),
      .addr_b_o (stk_addr2_o)
   );

   stkp_regs #(.BYTE_W(BYTE_W), .PTR_W(PTR_W), .RESET_LO(RESET_LO)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_lo_i  (wr_lo),
      .wr_hi_i  (wr_hi),
      .wdata_i  (sfr_wdata_i),
      .upd_i    (op != STK_IDLE),
      .nxt_lo_i (nxt_lo),
      .nxt_hi_i (nxt_hi),
      .lo_o     (ptr_lo),
      .hi_o     (ptr_hi)
   );

   always_comb begin
      sfr_rdata_o = '0;
      unique case (sfr_sel_i)
         SEL_LO:  sfr_rdata_o = ptr_lo;
         SEL_HI:  sfr_rdata_o = {{(BYTE_W-HI_W){1'b0}}, ptr_hi};
         SEL_CFG: sfr_rdata_o[EXT_BIT] = ext;
         default: sfr_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/stkp_chk.sv
`timescale 1ns/1ps
module stkp_chk #(
   parameter int BYTE_W = 8,
   parameter int PTR_W  = 11,
   localparam int HI_W  = PTR_W - BYTE_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [2:0]        op_i,
   input logic              sfr_wr_i,
   input logic [1:0]        sfr_sel_i,
   input logic [BYTE_W-1:0] sfr_wdata_i,
   input logic [BYTE_W-1:0] sfr_rdata_i,
   input logic [BYTE_W-1:0] lo_i,
   input logic [HI_W-1:0]   hi_i,
   input logic              ext_i,
   input logic [PTR_W-1:0]  addr_i
);
   logic [PTR_W-1:0] full;
   logic             ptr_wr;
   assign full   = {hi_i, lo_i};
   assign ptr_wr = sfr_wr_i && (sfr_sel_i == 2'd0 || sfr_sel_i == 2'd1);

   always @(negedge clk_i) begin
      if (!rst_ni) begin
         AST_RESET_STATE: assert (lo_i == 8'h07 && hi_i == '0 && !ext_i); // R1
      end
   end

   AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_i && op_i == 3'd1 && !ptr_wr) |=> full == PTR_W'($past(full) + PTR_W'(1))); // R2

   AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_i && op_i == 3'd2 && !ptr_wr) |=> full == PTR_W'($past(full) - PTR_W'(1))); // R3

   AST_CALL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_i && op_i == 3'd3 && !ptr_wr) |=> full == PTR_W'($past(full) + PTR_W'(2))); // R4

   AST_CLASSIC_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_i && !(sfr_wr_i && sfr_sel_i == 2'd1)) |=> $stable(hi_i)); // R5

   AST_HI_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sfr_sel_i == 2'd1) |-> sfr_rdata_i[BYTE_W-1:HI_W] == '0); // R7

   AST_SFR_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sfr_wr_i && sfr_sel_i == 2'd0) |=> lo_i == $past(sfr_wdata_i)); // R8

   AST_CLASSIC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ext_i |-> addr_i[PTR_W-1:BYTE_W] == '0); // R10
endmodule

bind stack_ptr_unit stkp_chk #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .op_i        (stk_op_i),
   .sfr_wr_i    (sfr_wr_i),
   .sfr_sel_i   (sfr_sel_i),
   .sfr_wdata_i (sfr_wdata_i),
   .sfr_rdata_i (sfr_rdata_o),
   .lo_i        (ptr_lo),
   .hi_i        (ptr_hi),
   .ext_i       (ext),
   .addr_i      (stk_addr_o)
);

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/1ps
module tb_stack_ptr_unit;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [2:0]  stk_op = 3'd0;
   logic [1:0]  sfr_sel = 2'd0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic [10:0] addr1, addr2;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   stack_ptr_unit dut (
      .clk_i(clk), .rst_ni(rst_ni), .stk_op_i(stk_op), .sfr_sel_i(sfr_sel),
      .sfr_wr_i(sfr_wr), .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata),
      .stk_addr_o(addr1), .stk_addr2_o(addr2)
   );

   function automatic logic [63:0] mk(input logic wr, input logic [1:0] sa, input logic [7:0] wd,
                                      input logic [2:0] op, input logic [10:0] a1, input logic [10:0] a2,
                                      input logic [7:0] lo, input logic [7:0] hi, input logic [3:0] rq);
      return {8'd0, wr, sa, wd, op, a1, a2, lo, hi, rq};
   endfunction

   localparam int NV = 21;
   localparam logic [63:0] VEC [0:NV-1] = '{
      mk(0, 0, 8'h00, 1, 11'h008, 11'h008, 8'h08, 8'h00, 1),  // R1 first push
      mk(0, 0, 8'h00, 1, 11'h009, 11'h009, 8'h09, 8'h00, 2),  // R2
      mk(0, 0, 8'h00, 2, 11'h009, 11'h009, 8'h08, 8'h00, 3),  // R3
      mk(0, 0, 8'h00, 3, 11'h009, 11'h00A, 8'h0A, 8'h00, 4),  // R4 call
      mk(0, 0, 8'h00, 4, 11'h00A, 11'h009, 8'h08, 8'h00, 4),  // R4 return
      mk(1, 1, 8'hFF, 0, 11'h008, 11'h008, 8'h08, 8'h07, 7),  // R7 upper bits dropped
      mk(0, 0, 8'h00, 1, 11'h009, 11'h009, 8'h09, 8'h07, 10), // R10 high ignored
      mk(1, 0, 8'hFF, 0, 11'h009, 11'h009, 8'hFF, 8'h07, 9),  // R9
      mk(0, 0, 8'h00, 1, 11'h000, 11'h000, 8'h00, 8'h07, 5),  // R5 wrap up
      mk(0, 0, 8'h00, 2, 11'h000, 11'h000, 8'hFF, 8'h07, 5),  // R5 wrap down
      mk(1, 2, 8'h80, 0, 11'h0FF, 11'h0FF, 8'hFF, 8'h07, 9),  // R9 enable extended
      mk(0, 0, 8'h00, 1, 11'h000, 11'h000, 8'h00, 8'h00, 6),  // R6 7FF -> 000
      mk(0, 0, 8'h00, 2, 11'h000, 11'h000, 8'hFF, 8'h07, 6),  // R6 000 -> 7FF
      mk(1, 1, 8'hF8, 0, 11'h7FF, 11'h7FF, 8'hFF, 8'h00, 7),  // R7
      mk(0, 0, 8'h00, 1, 11'h100, 11'h100, 8'h00, 8'h01, 6),  // R6 0FF -> 100
      mk(0, 0, 8'h00, 3, 11'h101, 11'h102, 8'h02, 8'h01, 4),  // R4 extended call
      mk(1, 0, 8'h55, 1, 11'h103, 11'h103, 8'h55, 8'h01, 8),  // R8 low write vs push
      mk(1, 1, 8'h03, 2, 11'h155, 11'h155, 8'h55, 8'h03, 8),  // R8 high write vs pop
      mk(0, 0, 8'h00, 4, 11'h355, 11'h354, 8'h53, 8'h03, 4),  // R4 extended return
      mk(1, 2, 8'h00, 0, 11'h353, 11'h353, 8'h53, 8'h03, 9),  // R9 back to classic
      mk(0, 0, 8'h00, 2, 11'h053, 11'h053, 8'h52, 8'h03, 10)  // R10
   };

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] val);
      sfr_sel = sel;
      #0.2;
      val = sfr_rdata;
   endtask

   initial begin
      logic [7:0] v;
      #50000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      // R1 reset state, R9 unused select
      rd(2'd0, v); chk("R1", "low byte", 16'(v), 16'h07);
      rd(2'd1, v); chk("R1", "high byte", 16'(v), 16'h00);
      rd(2'd2, v); chk("R1", "config", 16'(v), 16'h00);
      rd(2'd3, v); chk("R9", "select 3", 16'(v), 16'h00);

      for (int i = 0; i < NV; i++) begin
         logic        wr;
         logic [1:0]  sa;
         logic [7:0]  wd, elo, ehi, pad;
         logic [2:0]  op;
         logic [10:0] ea1, ea2;
         logic [3:0]  rq;
         string       rs;
         {pad, wr, sa, wd, op, ea1, ea2, elo, ehi, rq} = VEC[i];
         rs = $sformatf("R%0d", rq);
         @(negedge clk);
         sfr_wr = wr; sfr_sel = sa; sfr_wdata = wd; stk_op = op;
         #0.2;
         chk(rs, $sformatf("vec %0d addr1", i), 16'(addr1), 16'(ea1));
         chk(rs, $sformatf("vec %0d addr2", i), 16'(addr2), 16'(ea2));
         @(negedge clk);
         sfr_wr = 1'b0; stk_op = 3'd0; sfr_wdata = 8'h00;
         rd(2'd0, v); chk(rs, $sformatf("vec %0d low", i), 16'(v), 16'(elo));
         rd(2'd1, v); chk(rs, $sformatf("vec %0d high", i), 16'(v), 16'(ehi));
      end

      // R9 configuration readback keeps only bit 7
      @(negedge clk);
      sfr_wr = 1'b1; sfr_sel = 2'd2; sfr_wdata = 8'hFF;
      @(negedge clk);
      sfr_wr = 1'b0;
      rd(2'd2, v); chk("R9", "config readback", 16'(v), 16'h80);
      // R4 idle keeps the pointer: ext, ptr = 352
      sfr_sel = 2'd0; #0.2;
      chk("R4", "idle addr1", 16'(addr1), 16'h352);
      @(negedge clk);
      rd(2'd0, v); chk("R4", "idle low", 16'(v), 16'h52);

      // R1 reset in mid-run restores defaults
      rst_ni = 1'b0;
      @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      rd(2'd0, v); chk("R1", "low after reset", 16'(v), 16'h07);
      rd(2'd1, v); chk("R1", "high after reset", 16'(v), 16'h00);
      rd(2'd2, v); chk("R1", "config after reset", 16'(v), 16'h00);
      stk_op = 3'd1; #0.2;
      chk("R1", "first push addr", 16'(addr1), 16'h008);
      @(negedge clk);
      stk_op = 3'd0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule